// File: doc/BRIEF.md
# Register-File Stack Cache with Write-Back Bypass

This block keeps the operand stack and the method-local variable area of a stack-oriented execution core in one small register file. A stack index points at the top-of-stack entry and a frame-base index marks the first local variable. Each clock cycle the block accepts one command. The command is a two-operand arithmetic or logic step on the two topmost entries, a push of an external word, a push of a local variable, a pop into a local variable, a plain drop, or a frame-base update.

Operands are read and combined in an execute stage. The result is committed to the register file one cycle later from a write-back register. Any read in execute that names the entry still waiting in write-back takes the waiting value through a two-way select, and this is decided separately for each read port. The current top-of-stack value and the stack index are visible at the outputs at all times, so a surrounding core can observe them without stalling.

Top module: `rf_stack_cache`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the stack index and the frame-base index to 0 and cancels any pending write-back. After reset, `sp_o` reads 0 and a variable access at offset n reaches entry n.
- R2: Command codes 1 to 5 are add, subtract, and, or and xor. Each takes NOS (entry sp-1) and TOS (entry sp), with subtract computing NOS minus TOS. It stores the result in entry sp-1 and decrements sp by one.
- R3: Code 6 (drop) decrements sp and writes no entry.
- R4: Code 7 (push external) increments sp and stores `ext_data` in the new top entry.
- R5: Code 8 (variable load) reads entry vp+`var_off`, increments sp and stores that value in the new top entry.
- R6: Code 9 (variable store) writes TOS into entry vp+`var_off` and decrements sp.
- R7: Code 10 (set frame base) loads vp from `ext_data[3:0]` and leaves sp and every entry unchanged. No other command changes vp.
- R8: Code 0 and the unused codes 11 to 15 change neither sp, vp nor any entry.
- R9: A command that reads an entry written by the command of the previous cycle sees the new value, on each read port independently.
- R10: sp, vp and vp+`var_off` wrap modulo 16, and no overflow or underflow is flagged.
- R11: In each cycle, `tos_o` and `sp_o` show the top entry and the stack index that result from all commands accepted at earlier clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 4 | Stack command code for this cycle |
| var_off | input | 4 | Local variable offset added to the frame base |
| ext_data | input | 32 | External word for push and frame-base update |
| tos_o | output | 32 | Current top-of-stack value |
| sp_o | output | 4 | Current stack index |

## Verification
Two functions can fall in the same cycle. One is the commit of the previous result from write-back into the register file; the other is an execute-stage read of that same entry through the operand ports or the top-of-stack tap. The bench provokes this with back-to-back dependent commands: a push followed at once by an arithmetic step, a variable store followed at once by a load of that variable, and long random command streams. A reference model with no pipeline applies each command instantly to a plain array, and `tos_o` and `sp_o` are compared with that model after every edge, so any missing or misrouted bypass shows up as a stale value.

// File: rtl/stkc_pkg.sv
package stkc_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_DROP  = 4'd6,
    OP_PUSHX = 4'd7,
    OP_VLOAD = 4'd8,
    OP_VSTOR = 4'd9,
    OP_SETVP = 4'd10
  } stk_op_e;

  // two-operand arithmetic / logic step
  function automatic logic op_is_alu(input logic [3:0] op);
    return (op >= OP_ADD) && (op <= OP_XOR);
  endfunction

  // commands that grow the stack by one
  function automatic logic op_is_push(input logic [3:0] op);
    return (op == OP_PUSHX) || (op == OP_VLOAD);
  endfunction

  // commands that shrink the stack by one
  function automatic logic op_is_pop(input logic [3:0] op);
    return op_is_alu(op) || (op == OP_DROP) || (op == OP_VSTOR);
  endfunction

  // commands that leave a pending register-file write
  function automatic logic op_writes(input logic [3:0] op);
    return op_is_alu(op) || op_is_push(op) || (op == OP_VSTOR);
  endfunction

endpackage

// File: rtl/stkc_regfile.sv
module stkc_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int NRD    = 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NRD-1:0][AW-1:0]        raddr,
  output logic [NRD-1:0][DATA_W-1:0]    rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

endmodule

// File: rtl/stkc_bypass.sv
module stkc_bypass #(
  parameter int DATA_W = 32,
  parameter int AW     = 4,
  parameter int NRD    = 3
) (
  input  logic                          wb_valid,
  input  logic [AW-1:0]                 wb_addr,
  input  logic [DATA_W-1:0]             wb_data,
  input  logic [NRD-1:0][AW-1:0]        raddr,
  input  logic [NRD-1:0][DATA_W-1:0]    file_data,
  output logic [NRD-1:0][DATA_W-1:0]    rdata,
  output logic [NRD-1:0]                fwd_hit
);

  // one address compare and one 2:1 select per read port
  for (genvar g = 0; g < NRD; g++) begin : g_port
    assign fwd_hit[g] = wb_valid && (raddr[g] == wb_addr);
    assign rdata[g]   = fwd_hit[g] ? wb_data : file_data[g];
  end

endmodule

// File: rtl/stkc_ctrl.sv
module stkc_ctrl
  import stkc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cmd,
  input  logic [AW-1:0]     var_off,
  input  logic [DATA_W-1:0] ext_data,
  input  logic [DATA_W-1:0] opnd_top,
  input  logic [DATA_W-1:0] opnd_next,
  output logic [AW-1:0]     sp_q,
  output logic [AW-1:0]     vp_q,
  output logic [AW-1:0]     rd_addr_top,
  output logic [AW-1:0]     rd_addr_next,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_addr,
  output logic [DATA_W-1:0] wb_data
);

  function automatic logic [DATA_W-1:0] alu_eval(input logic [3:0] op,
                                                  input logic [DATA_W-1:0] nos,
                                                  input logic [DATA_W-1:0] tos);
    case (op)
      OP_ADD:  return nos + tos;
      OP_SUB:  return nos - tos;
      OP_AND:  return nos & tos;
      OP_OR:   return nos | tos;
      OP_XOR:  return nos ^ tos;
      default: return nos;
    endcase
  endfunction

  // named command events
  logic ev_alu, ev_push, ev_pop, ev_write, ev_vstor, ev_setvp;
  assign ev_alu   = op_is_alu(cmd);
  assign ev_push  = op_is_push(cmd);
  assign ev_pop   = op_is_pop(cmd);
  assign ev_write = op_writes(cmd);
  assign ev_vstor = (cmd == OP_VSTOR);
  assign ev_setvp = (cmd == OP_SETVP);

  logic [AW-1:0] var_addr, sp_up, sp_dn;
  assign var_addr = vp_q + var_off;
  assign sp_up    = sp_q + 1'b1;
  assign sp_dn    = sp_q - 1'b1;

  assign rd_addr_top  = (cmd == OP_VLOAD) ? var_addr : sp_q;
  assign rd_addr_next = sp_dn;

  logic [AW-1:0]     sp_n, vp_n, wa_n;
  logic [DATA_W-1:0] wd_n;

  always_comb begin
    sp_n = sp_q;
    vp_n = vp_q;
    wa_n = sp_q;
    wd_n = opnd_top;
    if (ev_alu) begin
      sp_n = sp_dn;
      wa_n = sp_dn;
      wd_n = alu_eval(cmd, opnd_next, opnd_top);
    end else if (cmd == OP_DROP) begin
      sp_n = sp_dn;
    end else if (cmd == OP_PUSHX) begin
      sp_n = sp_up;
      wa_n = sp_up;
      wd_n = ext_data;
    end else if (cmd == OP_VLOAD) begin
      sp_n = sp_up;
      wa_n = sp_up;
    end else if (ev_vstor) begin
      sp_n = sp_dn;
      wa_n = var_addr;
    end else if (ev_setvp) begin
      vp_n = ext_data[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q     <= '0;
      vp_q     <= '0;
      wb_valid <= 1'b0;
    end else begin
      sp_q     <= sp_n;
      vp_q     <= vp_n;
      wb_valid <= ev_write;
    end
    wb_addr <= wa_n;
    wb_data <= wd_n;
  end

  p_sp_down_r2: assert property (@(posedge clk) disable iff (rst)
    ev_pop |=> (sp_q == $past(sp_q) - 1'b1));

  p_sp_up_r5: assert property (@(posedge clk) disable iff (rst)
    ev_push |=> (sp_q == $past(sp_q) + 1'b1));

  p_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    !ev_write |=> !wb_valid);

  p_store_target_r6: assert property (@(posedge clk) disable iff (rst)
    ev_vstor |=> (wb_valid && wb_addr == $past(var_addr)));

  p_vp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ev_setvp |=> (vp_q == $past(vp_q)));

endmodule

// File: rtl/rf_stack_cache.sv
module rf_stack_cache
  import stkc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int NRD   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cmd,
  input  logic [AW-1:0]     var_off,
  input  logic [DATA_W-1:0] ext_data,
  output logic [DATA_W-1:0] tos_o,
  output logic [AW-1:0]     sp_o
);

  // read port 0: top operand / variable, 1: next operand, 2: top-of-stack tap
  logic [NRD-1:0][AW-1:0]     raddr;
  logic [NRD-1:0][DATA_W-1:0] file_data, rdata;
  logic [NRD-1:0]             fwd_hit;

  logic [AW-1:0]     sp_q, vp_q, rd_addr_top, rd_addr_next, wb_addr;
  logic              wb_valid;
  logic [DATA_W-1:0] wb_data;

  stkc_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmd),
    .var_off      (var_off),
    .ext_data     (ext_data),
    .opnd_top     (rdata[0]),
    .opnd_next    (rdata[1]),
    .sp_q         (sp_q),
    .vp_q         (vp_q),
    .rd_addr_top  (rd_addr_top),
    .rd_addr_next (rd_addr_next),
    .wb_valid     (wb_valid),
    .wb_addr      (wb_addr),
    .wb_data      (wb_data)
  );

  assign raddr[0] = rd_addr_top;
  assign raddr[1] = rd_addr_next;
  assign raddr[2] = sp_q;

  stkc_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NRD(NRD)) u_rf (
    .clk   (clk),
    .we    (wb_valid),
    .waddr (wb_addr),
    .wdata (wb_data),
    .raddr (raddr),
    .rdata (file_data)
  );

  stkc_bypass #(.DATA_W(DATA_W), .AW(AW), .NRD(NRD)) u_byp (
    .wb_valid  (wb_valid),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .raddr     (raddr),
    .file_data (file_data),
    .rdata     (rdata),
    .fwd_hit   (fwd_hit)
  );

  assign tos_o = rdata[2];
  assign sp_o  = sp_q;

  p_push_visible_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_PUSHX) |=> (tos_o == $past(ext_data)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_NOP) |=> (sp_o == $past(sp_o) && tos_o == $past(tos_o)));

endmodule

// File: tb/test_rf_stack_cache.sv
module test_rf_stack_cache;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cmd = 4'd0;
  logic [3:0]  var_off = 4'd0;
  logic [31:0] ext_data = 32'd0;
  logic [31:0] tos_o;
  logic [3:0]  sp_o;

  always #4 clk = ~clk;   // 125 MHz

  rf_stack_cache i_rf_stack_cache (
    .clk(clk), .rst(rst), .cmd(cmd), .var_off(var_off),
    .ext_data(ext_data), .tos_o(tos_o), .sp_o(sp_o)
  );

  int total = 0;
  int bad   = 0;

  // behavioural model: commands take effect instantly, no pipeline
  logic [31:0] m_mem [16];
  bit          m_known [16];
  logic [3:0]  m_sp = 4'd0;
  logic [3:0]  m_vp = 4'd0;

  task automatic model_apply(input logic [3:0] c, input logic [3:0] o, input logic [31:0] d);
    logic [3:0]  nx = m_sp - 4'd1;
    logic [3:0]  va = m_vp + o;
    logic [31:0] t  = m_mem[m_sp];
    logic [31:0] n  = m_mem[nx];
    bit          k  = m_known[m_sp] && m_known[nx];
    case (c)
      4'd1: begin m_mem[nx] = n + t; m_known[nx] = k; m_sp = nx; end
      4'd2: begin m_mem[nx] = n - t; m_known[nx] = k; m_sp = nx; end
      4'd3: begin m_mem[nx] = n & t; m_known[nx] = k; m_sp = nx; end
      4'd4: begin m_mem[nx] = n | t; m_known[nx] = k; m_sp = nx; end
      4'd5: begin m_mem[nx] = n ^ t; m_known[nx] = k; m_sp = nx; end
      4'd6: m_sp = nx;
      4'd7: begin m_sp = m_sp + 4'd1; m_mem[m_sp] = d; m_known[m_sp] = 1'b1; end
      4'd8: begin
        logic [31:0] v  = m_mem[va];
        bit          kv = m_known[va];
        m_sp = m_sp + 4'd1; m_mem[m_sp] = v; m_known[m_sp] = kv;
      end
      4'd9: begin
        bit kt = m_known[m_sp];
        m_mem[va] = t; m_known[va] = kt; m_sp = nx;
      end
      4'd10: m_vp = d[3:0];
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, {28'd0, sp_o}, {28'd0, m_sp});
    if (m_known[m_sp]) check(req, tos_o, m_mem[m_sp]);
  endtask

  // inputs change at the falling edge, outputs are read at the next falling edge
  task automatic issue(input logic [3:0] c, input logic [3:0] o, input logic [31:0] d,
                       input string req);
    cmd = c; var_off = o; ext_data = d;
    @(posedge clk);
    model_apply(c, o, d);
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1; cmd = 4'd0;
    repeat (n) @(posedge clk);
    m_sp = 4'd0; m_vp = 4'd0;
    @(negedge clk);
    rst = 1'b0;
    check("R1", {28'd0, sp_o}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_known[i] = 1'b0;
    @(negedge clk);
    do_reset(3);

    // R4 pushes, R2 and R9: arithmetic step right after the push it depends on
    issue(4'd7, 4'd0, 32'd5,          "R4");
    issue(4'd7, 4'd0, 32'd7,          "R4");
    issue(4'd1, 4'd0, 32'd0,          "R2 add R9");
    check("R2", tos_o, 32'd12);
    issue(4'd7, 4'd0, 32'd3,          "R4");
    issue(4'd2, 4'd0, 32'd0,          "R2 sub");
    check("R2", tos_o, 32'd9);
    issue(4'd7, 4'd0, 32'hF0F0_00FF,  "R4");
    issue(4'd3, 4'd0, 32'd0,          "R2 and");
    issue(4'd7, 4'd0, 32'h1234_0000,  "R4");
    issue(4'd4, 4'd0, 32'd0,          "R2 or");
    issue(4'd7, 4'd0, 32'hFFFF_FFFF,  "R4");
    issue(4'd5, 4'd0, 32'd0,          "R2 xor");

    // R8: idle and unused codes
    issue(4'd0,  4'd0, 32'hDEAD_BEEF, "R8");
    issue(4'd13, 4'd5, 32'hDEAD_BEEF, "R8");

    // R7 frame base, R6 store then R5 load of the same slot (R9 bypass)
    issue(4'd10, 4'd0, 32'd10,        "R7");
    issue(4'd7,  4'd0, 32'hCAFE_0001, "R4");
    issue(4'd7,  4'd0, 32'hCAFE_0002, "R4");
    issue(4'd9,  4'd1, 32'd0,         "R6");
    issue(4'd8,  4'd1, 32'd0,         "R5 R9");
    check("R5", tos_o, 32'hCAFE_0002);
    issue(4'd8,  4'd1, 32'd0,         "R5");

    // R3 drop
    issue(4'd6,  4'd0, 32'd0,         "R3");
    issue(4'd6,  4'd0, 32'd0,         "R3");

    // R10 wrap: push past entry 15, variable address past 15
    for (int i = 0; i < 18; i++) issue(4'd7, 4'd0, 32'h100 + i, "R10");
    issue(4'd10, 4'd0, 32'd14,        "R7");
    issue(4'd9,  4'd5, 32'd0,         "R10 R6");
    issue(4'd8,  4'd5, 32'd0,         "R10 R5");

    // R1: reset mid-stream, frame base returns to 0
    do_reset(2);
    issue(4'd6,  4'd0, 32'd0,         "R10 R3");
    check("R10", {28'd0, sp_o}, 32'd15);
    issue(4'd8,  4'd3, 32'd0,         "R1 R5");

    // R11: random streams compared on every cycle
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom_range(0, 15);
      logic [3:0] c = (r > 12) ? 4'd7 : r[3:0];
      issue(c, 4'($urandom_range(0, 15)), $urandom, "R11");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule